// File: doc/BRIEF.md
# Three-Wire Scratchpad Memory Slave

This block is a serial slave for a host port of three signals: a transaction enable that is active high, a shift clock driven by the host, and one data line that carries bits in both directions. The host frames each transaction by raising the enable. It clocks in a command byte and the arguments that command needs. For read commands it then clocks the reply out of the block.

Storage is a 32-byte scratchpad and a 512-byte memory array arranged as 16 pages of 32 bytes. Memory is never written directly. The host fills the scratchpad with a write-scratchpad command and can read it back to confirm the contents. It then commits the data with a copy command that must repeat the target address and end offset exactly. An authorisation flag, armed only by a complete write, guards the commit.

The pins are sampled into the system clock domain through a synchroniser. The data line is presented as a separate input, output and output-enable. The serial port has no back-pressure: the host paces every bit, and a read stream continues for as long as the host keeps clocking.

Top module: `tw_scratch_slave`

## Requirements
- R1: After reset, and whenever `xfer_en` is low, `sdata_oe` is 0. Dropping `xfer_en` at any bit abandons the transaction, and the next rise of `xfer_en` waits for a new command.
- R2: Every byte on the data line (command, argument or reply) is carried least significant bit first.
- R3: Read memory (command 8'hF0) takes the address bytes TA1 (low) and TA2 (high). It then streams memory bytes starting at address {TA2,TA1} modulo 512, so only TA2 bit 0 is used. The address increments per byte and wraps from 0x1FF to 0x000.
- R4: Write scratchpad (command 8'h0F) takes TA1 and TA2, then data. Data byte k goes to scratchpad offset TA1[4:0]+k, and bytes arriving after offset 31 has been filled are discarded. The end offset E is {3'b000, offset of the last stored byte}, or the start offset if no byte was stored. A trailing partial byte is not stored.
- R5: Read scratchpad (command 8'hAA) takes no arguments. It returns TA1, TA2 and E, then scratchpad bytes from offset TA1[4:0] upward, wrapping from 31 to 0.
- R6: Copy scratchpad (command 8'h55) takes three bytes. When they equal the latched TA1, TA2 and E and the flag is set, scratchpad offsets TA1[4:0]..E[4:0] are copied into memory page {TA2[0],TA1[7:5]} at the same offsets. No other memory byte changes.
- R7: A copy whose three bytes differ from the latched TA1, TA2 or E in any bit leaves memory unchanged.
- R8: The authorisation flag is set only when a write-scratchpad transaction ends with at least one data byte and no partial byte. A new write-scratchpad command clears it, and so does any copy command, whether or not the copy succeeds.
- R9: Any other command byte stops the transaction: the data line is not driven and no state changes until `xfer_en` falls.
- R10: Input bits are sampled on the rising edge of `shift_clk`. Reply bits are driven after each falling edge. `sdata_oe` rises only at the first falling edge of a read phase.
- R11: Reset clears memory, scratchpad, TA1, TA2, E and the authorisation flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_en | input | 1 | Transaction enable from the host, active high |
| shift_clk | input | 1 | Serial shift clock from the host |
| sdata_in | input | 1 | Data line value as seen at the pin |
| sdata_out | output | 1 | Data value the block drives during a read phase |
| sdata_oe | output | 1 | Output enable for the data line; 0 means released |

## Verification
The bench targets the authorisation guard. It tries a copy with a wrong end offset, a second copy that reuses a spent authorisation, a copy after a write cut off mid-byte, and a copy after a write that stopped at its address. A design that arms the flag too freely would overwrite memory in one of these cases, and the read-back would show it. It also writes past the end of the scratchpad, reads memory across the top address, and sets unused high address bits. Offset arithmetic that failed to stop or wrap would corrupt neighbouring bytes or return the wrong stream. An unknown command and an enable dropped in the middle of a read are checked at the output enable: a design that did not abandon these transactions would drive the line.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam logic [7:0] CMD_RD_MEM = 8'hF0;
  localparam logic [7:0] CMD_RD_SP  = 8'hAA;
  localparam logic [7:0] CMD_WR_SP  = 8'h0F;
  localparam logic [7:0] CMD_CP_SP  = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ARG,
    ST_WDATA,
    ST_RD,
    ST_HALT
  } tw_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RDMEM,
    OP_RDSP,
    OP_WRSP,
    OP_CPSP
  } tw_op_e;

endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  input  logic sclk_pin,
  input  logic dq_pin,
  output logic en_s,
  output logic dq_s,
  output logic sclk_rise,
  output logic sclk_fall
);

  localparam int LAST = STAGES - 1;

  logic [2:0] pipe_q [STAGES];
  logic       sclk_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= '0;
      sclk_d_q <= 1'b0;
    end else begin
      pipe_q[0] <= {en_pin, sclk_pin, dq_pin};
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
      sclk_d_q <= pipe_q[LAST][1];
    end
  end

  assign en_s      = pipe_q[LAST][2];
  assign dq_s      = pipe_q[LAST][0];
  assign sclk_rise = pipe_q[LAST][1] & ~sclk_d_q;
  assign sclk_fall = ~pipe_q[LAST][1] & sclk_d_q;

endmodule

// File: rtl/tw_tx_shift.sv
module tw_tx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       sclk_fall,
  input  logic [7:0] byte_in,
  output logic       dq_o,
  output logic       dq_oe,
  output logic       byte_sent
);

  logic [2:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      dq_o  <= 1'b0;
      dq_oe <= 1'b0;
    end else if (!active) begin
      bit_q <= '0;
      dq_o  <= 1'b0;
      dq_oe <= 1'b0;
    end else if (sclk_fall) begin
      dq_o  <= byte_in[bit_q];
      dq_oe <= 1'b1;
      bit_q <= bit_q + 3'd1;
    end
  end

  assign byte_sent = active && sclk_fall && (bit_q == 3'd7);

  // R10: line released one cycle after the read phase ends
  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !dq_oe);

  // R10: driving starts only on a falling shift-clock edge
  assert_oe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(sclk_fall));

endmodule

// File: rtl/tw_store.sv
module tw_store #(
  parameter  int PAGES      = 16,
  parameter  int PAGE_BYTES = 32,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int ADDR_W     = $clog2(PAGES * PAGE_BYTES),
  localparam int PG_W       = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_we,
  input  logic [OFF_W-1:0]  sp_woff,
  input  logic [7:0]        sp_wdata,
  input  logic [OFF_W-1:0]  sp_roff,
  output logic [7:0]        sp_rdata,
  input  logic [ADDR_W-1:0] mem_raddr,
  output logic [7:0]        mem_rdata,
  input  logic              copy_go,
  input  logic [PG_W-1:0]   copy_page,
  input  logic [OFF_W-1:0]  copy_lo,
  input  logic [OFF_W-1:0]  copy_hi
);

  logic [7:0] sp_q  [PAGE_BYTES];
  logic [7:0] mem_q [PAGES][PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < PAGE_BYTES; b++) sp_q[b] <= '0;
    end else if (sp_we) begin
      sp_q[sp_woff] <= sp_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++) mem_q[p][b] <= '0;
    end else if (copy_go) begin
      for (int p = 0; p < PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++)
          if ((PG_W'(p) == copy_page) && (OFF_W'(b) >= copy_lo) && (OFF_W'(b) <= copy_hi))
            mem_q[p][b] <= sp_q[b];
    end
  end

  assign sp_rdata  = sp_q[sp_roff];
  assign mem_rdata = mem_q[mem_raddr[ADDR_W-1:OFF_W]][mem_raddr[OFF_W-1:0]];

  // R6: a commit never sees an inverted offset window
  assert_copy_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |-> (copy_lo <= copy_hi));

  // R4: the scratchpad is never loaded in the same cycle as a commit
  assert_no_wr_during_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |-> !sp_we);

endmodule

// File: rtl/tw_proto_fsm.sv
module tw_proto_fsm
  import tw_pkg::*;
#(
  parameter  int PAGES      = 16,
  parameter  int PAGE_BYTES = 32,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int ADDR_W     = $clog2(PAGES * PAGE_BYTES),
  localparam int PG_W       = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              dq_s,
  input  logic              sclk_rise,
  input  logic              tx_next,
  input  logic [7:0]        sp_rdata,
  input  logic [7:0]        mem_rdata,
  output logic              sp_we,
  output logic [OFF_W-1:0]  sp_woff,
  output logic [7:0]        sp_wdata,
  output logic [OFF_W-1:0]  sp_roff,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              tx_active,
  output logic [7:0]        tx_byte,
  output logic              copy_go,
  output logic [PG_W-1:0]   copy_page,
  output logic [OFF_W-1:0]  copy_lo,
  output logic [OFF_W-1:0]  copy_hi
);

  tw_state_e         state_q;
  tw_op_e            op_q;
  logic [7:0]        rx_sh_q;
  logic [2:0]        rx_cnt_q;
  logic [1:0]        arg_idx_q;
  logic [7:0]        arg0_q, arg1_q;
  logic [7:0]        ta1_q, ta2_q, e_q;
  logic              auth_q, cp_auth_q;
  logic [OFF_W-1:0]  wr_off_q;
  logic              wr_full_q, wr_any_q;
  logic [ADDR_W-1:0] rd_ptr_q;
  logic [1:0]        rd_hdr_q;

  logic [7:0]        byte_next;
  logic              byte_done, shifting, args_match;
  logic [ADDR_W-1:0] ta_addr;

  assign byte_next  = {dq_s, rx_sh_q[7:1]};
  assign shifting   = sclk_rise && (state_q inside {ST_CMD, ST_ARG, ST_WDATA});
  assign byte_done  = shifting && (rx_cnt_q == 3'd7);
  assign args_match = (arg0_q == ta1_q) && (arg1_q == ta2_q) && (byte_next == e_q);
  assign ta_addr    = ADDR_W'({ta2_q, ta1_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_NONE;
      rx_sh_q   <= '0;
      rx_cnt_q  <= '0;
      arg_idx_q <= '0;
      arg0_q    <= '0;
      arg1_q    <= '0;
      ta1_q     <= '0;
      ta2_q     <= '0;
      e_q       <= '0;
      auth_q    <= 1'b0;
      cp_auth_q <= 1'b0;
      wr_off_q  <= '0;
      wr_full_q <= 1'b0;
      wr_any_q  <= 1'b0;
      rd_ptr_q  <= '0;
      rd_hdr_q  <= '0;
    end else if (!en_s) begin
      if (state_q == ST_WDATA && rx_cnt_q == 3'd0 && wr_any_q) auth_q <= 1'b1;
      state_q   <= ST_IDLE;
      op_q      <= OP_NONE;
      rx_cnt_q  <= '0;
      arg_idx_q <= '0;
    end else begin
      if (shifting) begin
        rx_sh_q  <= byte_next;
        rx_cnt_q <= rx_cnt_q + 3'd1;
      end
      unique case (state_q)
        ST_IDLE: state_q <= ST_CMD;
        ST_CMD: if (byte_done) begin
          arg_idx_q <= '0;
          unique case (byte_next)
            CMD_RD_MEM: begin op_q <= OP_RDMEM; state_q <= ST_ARG; end
            CMD_RD_SP: begin
              op_q     <= OP_RDSP;
              state_q  <= ST_RD;
              rd_hdr_q <= '0;
              rd_ptr_q <= ADDR_W'(ta1_q[OFF_W-1:0]);
            end
            CMD_WR_SP: begin op_q <= OP_WRSP; state_q <= ST_ARG; auth_q <= 1'b0; end
            CMD_CP_SP: begin
              op_q      <= OP_CPSP;
              state_q   <= ST_ARG;
              cp_auth_q <= auth_q;
              auth_q    <= 1'b0;
            end
            default: state_q <= ST_HALT;
          endcase
        end
        ST_ARG: if (byte_done) begin
          arg_idx_q <= arg_idx_q + 2'd1;
          if (arg_idx_q == 2'd0) arg0_q <= byte_next;
          if (arg_idx_q == 2'd1) arg1_q <= byte_next;
          if (arg_idx_q == 2'd1 && op_q == OP_RDMEM) begin
            rd_ptr_q <= ADDR_W'({byte_next, arg0_q});
            state_q  <= ST_RD;
          end
          if (arg_idx_q == 2'd1 && op_q == OP_WRSP) begin
            ta1_q     <= arg0_q;
            ta2_q     <= byte_next;
            e_q       <= 8'(arg0_q[OFF_W-1:0]);
            wr_off_q  <= arg0_q[OFF_W-1:0];
            wr_full_q <= 1'b0;
            wr_any_q  <= 1'b0;
            state_q   <= ST_WDATA;
          end
          if (arg_idx_q == 2'd2) state_q <= ST_HALT;
        end
        ST_WDATA: if (byte_done && !wr_full_q) begin
          e_q      <= 8'(wr_off_q);
          wr_any_q <= 1'b1;
          if (wr_off_q == OFF_W'(PAGE_BYTES - 1)) wr_full_q <= 1'b1;
          else wr_off_q <= wr_off_q + 1'b1;
        end
        ST_RD: if (tx_next) begin
          if (op_q == OP_RDMEM) rd_ptr_q <= rd_ptr_q + 1'b1;
          else if (rd_hdr_q != 2'd3) rd_hdr_q <= rd_hdr_q + 2'd1;
          else rd_ptr_q[OFF_W-1:0] <= rd_ptr_q[OFF_W-1:0] + 1'b1;
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sp_we     = (state_q == ST_WDATA) && byte_done && !wr_full_q;
  assign sp_woff   = wr_off_q;
  assign sp_wdata  = byte_next;
  assign sp_roff   = rd_ptr_q[OFF_W-1:0];
  assign mem_raddr = rd_ptr_q;
  assign tx_active = (state_q == ST_RD);

  always_comb begin
    if (op_q == OP_RDMEM) tx_byte = mem_rdata;
    else begin
      unique case (rd_hdr_q)
        2'd0:    tx_byte = ta1_q;
        2'd1:    tx_byte = ta2_q;
        2'd2:    tx_byte = e_q;
        default: tx_byte = sp_rdata;
      endcase
    end
  end

  assign copy_go   = (state_q == ST_ARG) && (op_q == OP_CPSP) && (arg_idx_q == 2'd2) &&
                     byte_done && cp_auth_q && args_match;
  assign copy_page = ta_addr[ADDR_W-1:OFF_W];
  assign copy_lo   = ta_addr[OFF_W-1:0];
  assign copy_hi   = e_q[OFF_W-1:0];

  // R8: the flag only arms as a write transaction closes
  assert_auth_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auth_q) |-> ($past(state_q) == ST_WDATA) && !$past(en_s));

  // R8: a commit leaves the flag spent
  assert_auth_spent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |=> !auth_q);

  // R9: a stopped transaction stays stopped while enabled
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && en_s) |=> (state_q == ST_HALT));

  // R1: losing the enable always returns to idle
  assert_idle_on_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (state_q == ST_IDLE));

endmodule

// File: rtl/tw_scratch_slave.sv
module tw_scratch_slave #(
  parameter int PAGES       = 16,
  parameter int PAGE_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_en,
  input  logic shift_clk,
  input  logic sdata_in,
  output logic sdata_out,
  output logic sdata_oe
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int ADDR_W = $clog2(PAGES * PAGE_BYTES);
  localparam int PG_W   = ADDR_W - OFF_W;

  logic              en_s, dq_s, rise, fall;
  logic              tx_next, tx_active;
  logic [7:0]        tx_byte;
  logic              sp_we;
  logic [OFF_W-1:0]  sp_woff, sp_roff;
  logic [7:0]        sp_wdata, sp_rdata, mem_rdata;
  logic [ADDR_W-1:0] mem_raddr;
  logic              copy_go;
  logic [PG_W-1:0]   copy_page;
  logic [OFF_W-1:0]  copy_lo, copy_hi;

  tw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .en_pin(xfer_en), .sclk_pin(shift_clk), .dq_pin(sdata_in),
    .en_s(en_s), .dq_s(dq_s), .sclk_rise(rise), .sclk_fall(fall)
  );

  tw_proto_fsm #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .en_s(en_s), .dq_s(dq_s), .sclk_rise(rise), .tx_next(tx_next),
    .sp_rdata(sp_rdata), .mem_rdata(mem_rdata),
    .sp_we(sp_we), .sp_woff(sp_woff), .sp_wdata(sp_wdata), .sp_roff(sp_roff),
    .mem_raddr(mem_raddr), .tx_active(tx_active), .tx_byte(tx_byte),
    .copy_go(copy_go), .copy_page(copy_page), .copy_lo(copy_lo), .copy_hi(copy_hi)
  );

  tw_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .sp_we(sp_we), .sp_woff(sp_woff), .sp_wdata(sp_wdata),
    .sp_roff(sp_roff), .sp_rdata(sp_rdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .copy_go(copy_go), .copy_page(copy_page), .copy_lo(copy_lo), .copy_hi(copy_hi)
  );

  tw_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n),
    .active(tx_active), .sclk_fall(fall), .byte_in(tx_byte),
    .dq_o(sdata_out), .dq_oe(sdata_oe), .byte_sent(tx_next)
  );

endmodule

// File: tb/tw_scratch_slave_bench.sv
module tw_scratch_slave_bench;

  logic clk = 1'b0, rst_n = 1'b0, xen = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, soe;
  int   n_chk = 0, n_err = 0;

  logic [7:0] mem_m [512];
  logic [7:0] sp_m  [32];
  logic [7:0] ta1_m = 8'h00, ta2_m = 8'h00, e_m = 8'h00;
  bit         auth_m = 1'b0;

  // {TA1, TA2, data length, data seed}
  localparam logic [31:0] VEC [6] = '{
    32'h00_00_04_11, 32'h3C_00_03_5A, 32'hE5_01_06_C3,
    32'h7E_FE_05_90, 32'h41_01_08_2D, 32'hA0_00_01_07
  };

  always #5 clk = ~clk;

  tw_scratch_slave u_tw_scratch_slave (
    .clk(clk), .rst_n(rst_n), .xfer_en(xen), .shift_clk(sck),
    .sdata_in(sdi), .sdata_out(sdo), .sdata_oe(soe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (10) @(negedge clk);
  endtask

  task automatic tx_begin();
    xen = 1'b1; sck = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_end();
    repeat (4) @(negedge clk);
    xen = 1'b0; sck = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; sdi = b[i]; half();
      sck = 1'b1; half();
    end
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; half();
      b[i] = sdo;
      sck = 1'b1; half();
    end
  endtask

  task automatic write_sp(input logic [7:0] a1, input logic [7:0] a2, input int n,
                          input logic [7:0] seed, input bit partial);
    logic [4:0] off;
    bit full;
    tx_begin();
    put_byte(8'h0F);
    auth_m = 1'b0;
    put_byte(a1); put_byte(a2);
    ta1_m = a1; ta2_m = a2; e_m = {3'b000, a1[4:0]};
    off = a1[4:0]; full = 1'b0;
    chk(soe == 1'b0, "R10 write phase oe", int'(soe), 0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = seed + 8'(k * 37);
      put_byte(d);
      if (!full) begin
        sp_m[off] = d; e_m = {3'b000, off};
        if (off == 5'd31) full = 1'b1; else off = off + 5'd1;
      end
    end
    if (partial) begin
      for (int i = 0; i < 3; i++) begin
        sck = 1'b0; sdi = i[0]; half(); sck = 1'b1; half();
      end
    end
    tx_end();
    if (n > 0 && !partial) auth_m = 1'b1;
  endtask

  task automatic copy_sp(input logic [7:0] a1, input logic [7:0] a2, input logic [7:0] e);
    bit ok;
    tx_begin();
    put_byte(8'h55);
    ok = auth_m && a1 == ta1_m && a2 == ta2_m && e == e_m;
    auth_m = 1'b0;
    put_byte(a1); put_byte(a2); put_byte(e);
    tx_end();
    if (ok)
      for (int i = int'(ta1_m[4:0]); i <= int'(e_m[4:0]); i++)
        mem_m[{ta2_m[0], ta1_m[7:5], 5'(i)}] = sp_m[i];
  endtask

  task automatic read_mem(input logic [7:0] a1, input logic [7:0] a2, input int n,
                          input string tag);
    logic [8:0] a;
    logic [7:0] b;
    tx_begin();
    put_byte(8'hF0); put_byte(a1); put_byte(a2);
    chk(soe == 1'b0, "R10 oe before first fall", int'(soe), 0);
    a = {a2[0], a1};
    for (int k = 0; k < n; k++) begin
      get_byte(b);
      chk(b == mem_m[a], tag, int'(b), int'(mem_m[a]));
      if (k == 0) chk(soe == 1'b1, "R10 oe in read phase", int'(soe), 1);
      a = a + 9'd1;
    end
    tx_end();
    chk(soe == 1'b0, "R1 oe after enable drop", int'(soe), 0);
  endtask

  task automatic read_sp(input int n, input string tag);
    logic [7:0] b;
    logic [4:0] off;
    tx_begin();
    put_byte(8'hAA);
    get_byte(b); chk(b == ta1_m, "R2 header TA1 bit order", int'(b), int'(ta1_m));
    get_byte(b); chk(b == ta2_m, "R5 header TA2", int'(b), int'(ta2_m));
    get_byte(b); chk(b == e_m, "R5 header E", int'(b), int'(e_m));
    off = ta1_m[4:0];
    for (int k = 0; k < n; k++) begin
      get_byte(b);
      chk(b == sp_m[off], tag, int'(b), int'(sp_m[off]));
      off = off + 5'd1;
    end
    tx_end();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired before the run completed");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
    for (int i = 0; i < 32; i++) sp_m[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(soe == 1'b0, "R1 oe during reset", int'(soe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(soe == 1'b0, "R1 oe after reset", int'(soe), 0);

    // R11: reset contents
    read_mem(8'hF8, 8'h01, 3, "R11 memory zero after reset");
    read_sp(2, "R11 scratchpad zero after reset");

    // Table walk: stage, read back, commit, check memory
    for (int v = 0; v < 6; v++) begin
      write_sp(VEC[v][31:24], VEC[v][23:16], int'(VEC[v][15:8]), VEC[v][7:0], 1'b0);
      read_sp(int'(VEC[v][15:8]), "R4 scratchpad contents");
      copy_sp(VEC[v][31:24], VEC[v][23:16], e_m);
      read_mem(VEC[v][31:24], VEC[v][23:16], int'(VEC[v][15:8]) + 2, "R6 committed memory");
    end

    // R3: wrap across top address and ignored high address bits
    read_mem(8'hFE, 8'h01, 4, "R3 wrap past top address");
    read_mem(8'h7E, 8'hFE, 2, "R3 high address bits ignored");

    // R5: scratchpad read wraps around the page
    read_sp(34, "R5 scratchpad wrap");

    // R7: mismatched end offset, then R8: spent authorisation
    write_sp(8'h20, 8'h00, 3, 8'h66, 1'b0);
    copy_sp(8'h20, 8'h00, e_m + 8'd1);
    read_mem(8'h20, 8'h00, 3, "R7 no commit on mismatch");
    copy_sp(8'h20, 8'h00, e_m);
    read_mem(8'h20, 8'h00, 3, "R8 flag spent by failed copy");

    // R8: new write command with no data clears the flag
    write_sp(8'h60, 8'h00, 2, 8'h31, 1'b0);
    write_sp(8'h60, 8'h00, 0, 8'h00, 1'b0);
    copy_sp(8'h60, 8'h00, e_m);
    read_mem(8'h60, 8'h00, 2, "R8 flag cleared by new write");

    // R8 / R4: partial trailing byte
    write_sp(8'h84, 8'h00, 2, 8'hD2, 1'b1);
    read_sp(3, "R4 partial byte not stored");
    copy_sp(8'h84, 8'h00, e_m);
    read_mem(8'h84, 8'h00, 2, "R8 no flag after partial byte");

    // R9: unknown command
    tx_begin();
    put_byte(8'h33);
    get_byte(b);
    chk(soe == 1'b0, "R9 line released after unknown command", int'(soe), 0);
    put_byte(8'hF0);
    put_byte(8'h00);
    put_byte(8'h00);
    sck = 1'b0; half();
    chk(soe == 1'b0, "R9 later bytes ignored", int'(soe), 0);
    tx_end();
    read_sp(2, "R9 scratchpad untouched");

    // R1: enable dropped mid read
    tx_begin();
    put_byte(8'hF0); put_byte(8'h00); put_byte(8'h00);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; half(); sck = 1'b1; half();
    end
    chk(soe == 1'b1, "R10 driving mid byte", int'(soe), 1);
    xen = 1'b0; sck = 1'b0;
    repeat (12) @(negedge clk);
    chk(soe == 1'b0, "R1 released on enable drop", int'(soe), 0);
    read_mem(8'h00, 8'h00, 2, "R1 fresh transaction after abort");

    finish_run();
  end

endmodule